// File: doc/BRIEF.md
# Decimal-Capable Arithmetic Unit with Status Flags

This unit performs the arithmetic for a group of instructions of an 8-bit accumulator-style processor. Each cycle it takes a destination byte, a source byte, an extra high byte for 16-bit work, the incoming carry, negative, zero and interrupt-enable status bits, and a 3-bit operation select. It returns the result bytes, a write-enable that tells the datapath whether to store the result, the updated status bits, and a nonzero indication for the decrement-and-branch instruction.

The operations are unsigned compare, packed-decimal add with carry, packed-decimal subtract in which carry acts as not-borrow, byte decrement, 16-bit register-pair decrement, and a decrement that leaves the status bits alone for loop counting. The arithmetic is combinational. All outputs are registered once, so a result appears one clock after its operands. Operand fetch, decode and branch target arithmetic belong to the surrounding core.

Top module: `dalu_top`

## Requirements
- R1: With op 0 (compare), wr_o is 0. c_o is 1 exactly when dst_i >= src_i as unsigned values. n_o is bit 7 of (dst_i - src_i) mod 256, and z_o is 1 exactly when that byte is zero.
- R2: With op 1 (decimal add), given valid packed-BCD operands (high nibble tens, low nibble units), res_lo_o is the packed-BCD form of (dst + src + cin_i) mod 100. c_o is 1 exactly when that sum exceeds 99, and wr_o is 1.
- R3: With op 2 (decimal subtract), let v = dst - src - 1 + cin_i in decimal. If v >= 0, res_lo_o is packed BCD of v and c_o is 1. Otherwise res_lo_o is packed BCD of v + 100 and c_o is 0. wr_o is 1.
- R4: With op 3 (byte decrement), res_lo_o is (dst_i - 1) mod 256 and wr_o is 1. c_o is 0 only when dst_i is 00 and is 1 otherwise.
- R5: With op 4 (pair decrement), {res_hi_o,res_lo_o} is ({hi_i,dst_i} - 1) mod 65536 and wr_o is 1. c_o is 0 only on the wrap from 0000 to FFFF. n_o is bit 15 of the result, and z_o is 1 only when all 16 bits are zero.
- R6: With op 5 (loop decrement), res_lo_o is (dst_i - 1) mod 256 and wr_o is 1. c_o, n_o and z_o equal cin_i, nin_i and zin_i. nz_o is 1 exactly when the new value is nonzero.
- R7: For every op, i_o equals iin_i from the same input cycle.
- R8: For ops 1 to 4, n_o is bit 7 of res_lo_o (bit 15 of the pair for op 4). For ops 1 to 3, z_o is 1 exactly when res_lo_o is zero.
- R9: Ops 6 and 7 have no effect: wr_o is 0, the result bytes are 0, and c_o, n_o, z_o equal their inputs. res_hi_o is 0 for every op other than 4, and nz_o is 0 for every op other than 5.
- R10: Outputs follow inputs with one clock of latency. While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation select |
| dst_i | input | 8 | Destination operand, low byte for pair decrement |
| src_i | input | 8 | Source operand |
| hi_i | input | 8 | High byte for pair decrement |
| cin_i | input | 1 | Incoming carry status |
| nin_i | input | 1 | Incoming negative status |
| zin_i | input | 1 | Incoming zero status |
| iin_i | input | 1 | Incoming interrupt-enable status |
| res_lo_o | output | 8 | Result low byte |
| res_hi_o | output | 8 | Result high byte (pair decrement) |
| wr_o | output | 1 | Result is to be stored |
| c_o | output | 1 | Updated carry |
| n_o | output | 1 | Updated negative |
| z_o | output | 1 | Updated zero |
| i_o | output | 1 | Interrupt-enable status, passed through |
| nz_o | output | 1 | Loop-decrement result is nonzero |

## Verification
The decimal operations are defined only for operands in which both nibbles are 0 to 9. No assertion tests decimal results, because a correct design gives arbitrary but harmless values outside that domain. The assertions cover only write suppression, flag preservation, interrupt-enable pass-through and the pair-decrement wrap, which hold for any input. The decimal stimulus is produced by converting integers 0 to 99 into packed form, so every sweep stays inside the valid domain. The binary operations are driven with arbitrary bytes, including 00, 01, 7F, 80 and FF.

// File: rtl/dalu_pkg.sv
package dalu_pkg;
    localparam int BYTE_W = 8;
    localparam int PAIR_W = 2 * BYTE_W;

    typedef enum logic [2:0] {
        OP_CMP  = 3'd0,
        OP_DAC  = 3'd1,
        OP_DSB  = 3'd2,
        OP_DEC  = 3'd3,
        OP_DECD = 3'd4,
        OP_DJNZ = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_e;

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic              wr;
        logic              c;
        logic              n;
        logic              z;
        logic              i;
        logic              nz;
    } alu_out_t;
endpackage

// File: rtl/dalu_bcd_digit.sv
module dalu_bcd_digit #(
    parameter bit SUB = 1'b0
) (
    input  logic [3:0] a,
    input  logic [3:0] b,
    input  logic       ci,
    output logic [3:0] s,
    output logic       co
);
    logic [4:0] raw;

    generate
        if (SUB) begin : g_sub
            // ci/co are borrows here
            always_comb begin
                raw = {1'b0, a} - {1'b0, b} - {4'b0, ci};
                if (raw[4]) begin
                    s  = raw[3:0] - 4'd6;
                    co = 1'b1;
                end else begin
                    s  = raw[3:0];
                    co = 1'b0;
                end
            end
        end else begin : g_add
            always_comb begin
                raw = {1'b0, a} + {1'b0, b} + {4'b0, ci};
                if (raw > 5'd9) begin
                    s  = raw[3:0] + 4'd6;
                    co = 1'b1;
                end else begin
                    s  = raw[3:0];
                    co = 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/dalu_bcd_unit.sv
module dalu_bcd_unit #(
    parameter int W   = 8,
    parameter bit SUB = 1'b0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         cout
);
    localparam int DIGITS = W / 4;

    logic [DIGITS:0] chain;

    // subtract: carry-in means "no borrow"
    assign chain[0] = SUB ? ~cin : cin;
    assign cout     = SUB ? ~chain[DIGITS] : chain[DIGITS];

    generate
        for (genvar g = 0; g < DIGITS; g++) begin : g_dig
            dalu_bcd_digit #(.SUB(SUB)) u_digit (
                .a  (a[4*g +: 4]),
                .b  (b[4*g +: 4]),
                .ci (chain[g]),
                .s  (s[4*g +: 4]),
                .co (chain[g+1])
            );
        end
    endgenerate
endmodule

// File: rtl/dalu_dec.sv
module dalu_dec #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    output logic [W-1:0] res,
    output logic         no_borrow
);
    assign res       = val - {{(W-1){1'b0}}, 1'b1};
    assign no_borrow = |val;
endmodule

// File: rtl/dalu_top.sv
module dalu_top
    import dalu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [BYTE_W-1:0] dst_i,
    input  logic [BYTE_W-1:0] src_i,
    input  logic [BYTE_W-1:0] hi_i,
    input  logic              cin_i,
    input  logic              nin_i,
    input  logic              zin_i,
    input  logic              iin_i,
    output logic [BYTE_W-1:0] res_lo_o,
    output logic [BYTE_W-1:0] res_hi_o,
    output logic              wr_o,
    output logic              c_o,
    output logic              n_o,
    output logic              z_o,
    output logic              i_o,
    output logic              nz_o
);
    op_e               op;
    logic [BYTE_W:0]   diff;
    logic [BYTE_W-1:0] dac_s, dsb_s, dec8_s;
    logic              dac_c, dsb_c, dec8_c;
    logic [PAIR_W-1:0] dec16_s;
    logic              dec16_c;
    alu_out_t          r_d, r_q;

    assign op   = op_e'(op_i);
    assign diff = {1'b0, dst_i} - {1'b0, src_i};

    dalu_bcd_unit #(.W(BYTE_W), .SUB(1'b0)) u_dac (
        .a(dst_i), .b(src_i), .cin(cin_i), .s(dac_s), .cout(dac_c)
    );

    dalu_bcd_unit #(.W(BYTE_W), .SUB(1'b1)) u_dsb (
        .a(dst_i), .b(src_i), .cin(cin_i), .s(dsb_s), .cout(dsb_c)
    );

    dalu_dec #(.W(BYTE_W)) u_dec8 (
        .val(dst_i), .res(dec8_s), .no_borrow(dec8_c)
    );

    dalu_dec #(.W(PAIR_W)) u_dec16 (
        .val({hi_i, dst_i}), .res(dec16_s), .no_borrow(dec16_c)
    );

    always_comb begin
        r_d    = '0;
        r_d.c  = cin_i;
        r_d.n  = nin_i;
        r_d.z  = zin_i;
        r_d.i  = iin_i;
        unique case (op)
            OP_CMP: begin
                r_d.lo = diff[BYTE_W-1:0];
                r_d.c  = ~diff[BYTE_W];
                r_d.n  = diff[BYTE_W-1];
                r_d.z  = (diff[BYTE_W-1:0] == '0);
            end
            OP_DAC: begin
                r_d.lo = dac_s;
                r_d.wr = 1'b1;
                r_d.c  = dac_c;
                r_d.n  = dac_s[BYTE_W-1];
                r_d.z  = (dac_s == '0);
            end
            OP_DSB: begin
                r_d.lo = dsb_s;
                r_d.wr = 1'b1;
                r_d.c  = dsb_c;
                r_d.n  = dsb_s[BYTE_W-1];
                r_d.z  = (dsb_s == '0);
            end
            OP_DEC: begin
                r_d.lo = dec8_s;
                r_d.wr = 1'b1;
                r_d.c  = dec8_c;
                r_d.n  = dec8_s[BYTE_W-1];
                r_d.z  = (dec8_s == '0);
            end
            OP_DECD: begin
                r_d.lo = dec16_s[BYTE_W-1:0];
                r_d.hi = dec16_s[PAIR_W-1:BYTE_W];
                r_d.wr = 1'b1;
                r_d.c  = dec16_c;
                r_d.n  = dec16_s[PAIR_W-1];
                r_d.z  = (dec16_s == '0);
            end
            OP_DJNZ: begin
                r_d.lo = dec8_s;
                r_d.wr = 1'b1;
                r_d.nz = (dec8_s != '0);
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign res_lo_o = r_q.lo;
    assign res_hi_o = r_q.hi;
    assign wr_o     = r_q.wr;
    assign c_o      = r_q.c;
    assign n_o      = r_q.n;
    assign z_o      = r_q.z;
    assign i_o      = r_q.i;
    assign nz_o     = r_q.nz;

    a_r1_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CMP) |=> !wr_o);

    a_r6_loop_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_DJNZ) |=> (c_o == $past(cin_i) && n_o == $past(nin_i) && z_o == $past(zin_i)));

    a_r7_ie_pass: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (i_o == $past(iin_i)));

    a_r5_pair_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_DECD && dst_i == '0 && hi_i == '0) |=> (!c_o && res_hi_o == '1 && res_lo_o == '1));

    a_r9_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_RSV6 || op_i == OP_RSV7) |=> (!wr_o && !nz_o && c_o == $past(cin_i)));
endmodule

// File: tb/tb_dalu_top.sv
module tb_dalu_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] op_i;
    logic [7:0] dst_i, src_i, hi_i;
    logic       cin_i, nin_i, zin_i, iin_i;
    logic [7:0] res_lo_o, res_hi_o;
    logic       wr_o, c_o, n_o, z_o, i_o, nz_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dalu_top dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .dst_i(dst_i), .src_i(src_i),
        .hi_i(hi_i), .cin_i(cin_i), .nin_i(nin_i), .zin_i(zin_i), .iin_i(iin_i),
        .res_lo_o(res_lo_o), .res_hi_o(res_hi_o), .wr_o(wr_o), .c_o(c_o),
        .n_o(n_o), .z_o(z_o), .i_o(i_o), .nz_o(nz_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    // drive on falling edge, result is registered on next rising edge
    task automatic apply(input logic [2:0] op, input logic [7:0] d, input logic [7:0] s,
                         input logic [7:0] h, input logic c, input logic n,
                         input logic z, input logic i);
        @(negedge clk);
        op_i = op; dst_i = d; src_i = s; hi_i = h;
        cin_i = c; nin_i = n; zin_i = z; iin_i = i;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        op_i = 3'd1; dst_i = 8'h99; src_i = 8'h99; hi_i = 8'hFF;
        cin_i = 1'b1; nin_i = 1'b1; zin_i = 1'b1; iin_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 reset outputs", {res_lo_o, res_hi_o, wr_o, c_o, n_o, z_o, i_o, nz_o}, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_cmp();
        logic [7:0] pat [6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFE, 8'hFF};
        foreach (pat[x]) foreach (pat[y]) begin
            logic [7:0] dif;
            dif = pat[x] - pat[y];
            apply(3'd0, pat[x], pat[y], 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
            chk("R1 cmp wr", wr_o, 0);
            chk("R1 cmp c", c_o, int'(pat[x] >= pat[y]));
            chk("R1 cmp n", n_o, dif[7]);
            chk("R1 cmp z", z_o, int'(dif == 0));
        end
    endtask

    task automatic t_dac();
        for (int a = 0; a < 100; a++)
            for (int b = 0; b < 100; b++)
                for (int c = 0; c < 2; c++) begin
                    int sum;
                    logic [7:0] e;
                    sum = a + b + c;
                    e = to_bcd(sum % 100);
                    apply(3'd1, to_bcd(a), to_bcd(b), 8'h00, c[0], 1'b0, 1'b0, 1'b0);
                    chk("R2 dac result/c/wr", {res_lo_o, c_o, wr_o}, {e, sum > 99, 1'b1});
                    chk("R8 dac n/z", {n_o, z_o}, {e[7], e == 0});
                end
    endtask

    task automatic t_dsb();
        for (int a = 0; a < 100; a++)
            for (int b = 0; b < 100; b++)
                for (int c = 0; c < 2; c++) begin
                    int v;
                    logic ec;
                    logic [7:0] e;
                    v = a - b - 1 + c;
                    ec = (v >= 0);
                    if (v < 0) v += 100;
                    e = to_bcd(v);
                    apply(3'd2, to_bcd(a), to_bcd(b), 8'h00, c[0], 1'b0, 1'b0, 1'b0);
                    chk("R3 dsb result/c/wr", {res_lo_o, c_o, wr_o}, {e, ec, 1'b1});
                    chk("R8 dsb n/z", {n_o, z_o}, {e[7], e == 0});
                end
    endtask

    task automatic t_dec();
        logic [7:0] pat [6] = '{8'h00, 8'h01, 8'h02, 8'h80, 8'h81, 8'hFF};
        foreach (pat[x]) begin
            logic [7:0] e;
            e = pat[x] - 8'd1;
            apply(3'd3, pat[x], 8'h55, 8'h00, ~pat[x][0], 1'b0, 1'b0, 1'b0);
            chk("R4 dec result/wr", {res_lo_o, wr_o}, {e, 1'b1});
            chk("R4 dec c", c_o, int'(pat[x] != 0));
            chk("R8 dec n/z", {n_o, z_o}, {e[7], e == 0});
            chk("R9 dec hi/nz", {res_hi_o, nz_o}, 0);
        end
    endtask

    task automatic t_decd();
        logic [15:0] pat [7] = '{16'h0000, 16'h0001, 16'h0100, 16'h8000,
                                 16'h8001, 16'hFFFF, 16'h1234};
        foreach (pat[x]) begin
            logic [15:0] e;
            e = pat[x] - 16'd1;
            apply(3'd4, pat[x][7:0], 8'h00, pat[x][15:8], 1'b1, 1'b0, 1'b1, 1'b0);
            chk("R5 decd result/wr", {res_hi_o, res_lo_o, wr_o}, {e, 1'b1});
            chk("R5 decd c", c_o, int'(pat[x] != 0));
            chk("R5 decd n/z", {n_o, z_o}, {e[15], e == 0});
        end
    endtask

    task automatic t_djnz();
        logic [7:0] pat [5] = '{8'h00, 8'h01, 8'h02, 8'h80, 8'hFF};
        foreach (pat[x]) for (int f = 0; f < 8; f++) begin
            logic [7:0] e;
            e = pat[x] - 8'd1;
            apply(3'd5, pat[x], 8'h00, 8'h00, f[0], f[1], f[2], 1'b0);
            chk("R6 djnz result/wr", {res_lo_o, wr_o}, {e, 1'b1});
            chk("R6 djnz flags kept", {c_o, n_o, z_o}, {f[0], f[1], f[2]});
            chk("R6 djnz nz", nz_o, int'(e != 0));
        end
    endtask

    task automatic t_ie();
        for (int o = 0; o < 8; o++)
            for (int i = 0; i < 2; i++) begin
                apply(3'(o), 8'h00, 8'h01, 8'h00, 1'b0, 1'b1, 1'b0, i[0]);
                chk("R7 ie pass", i_o, i);
            end
    endtask

    task automatic t_reserved();
        for (int o = 6; o < 8; o++)
            for (int f = 0; f < 8; f++) begin
                apply(3'(o), 8'h42, 8'h17, 8'h9A, f[0], f[1], f[2], 1'b0);
                chk("R9 reserved no write", {wr_o, res_lo_o, res_hi_o, nz_o}, 0);
                chk("R9 reserved flags", {c_o, n_o, z_o}, {f[0], f[1], f[2]});
            end
    endtask

    task automatic t_latency();
        @(negedge clk);
        op_i = 3'd3; dst_i = 8'h10;
        @(posedge clk);
        op_i = 3'd3; dst_i = 8'h10;
        #1;
        chk("R10 latency first", res_lo_o, 8'h0F);
        @(negedge clk);
        dst_i = 8'h20;
        #1;
        chk("R10 latency hold", res_lo_o, 8'h0F);
        @(negedge clk);
        chk("R10 latency update", res_lo_o, 8'h1F);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_cmp();
        t_dac();
        t_dsb();
        t_dec();
        t_decd();
        t_djnz();
        t_ie();
        t_reserved();
        t_latency();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule